// File: doc/BRIEF.md
# Segment-Indexed Signed Dot-Product Accumulator

This block is a vector datapath that multiplies packed signed integers and accumulates the results. Every accumulator lane of the vector takes four signed sub-elements from the first source. It multiplies each of them by the matching sub-element of one group taken from the second source, adds the four products to its current value, and returns the sum in place of the accumulator. The second source group is not taken lane by lane. A small immediate index picks one group position inside every 128-bit segment of the second source, and that group is shared by every lane of the same segment.

Two lane formats are supported. Signed bytes accumulate into 32-bit lanes, and signed halfwords accumulate into 64-bit lanes. The vector width is a parameter and must be a whole number of 128-bit segments. An operation is presented with a single-cycle valid strobe, together with the three operands, the format select and the index. The result appears one cycle later with its own valid flag. Every lane is written on every operation, and lane sums wrap at the lane width.

Top module: `seg_dot_acc`

## Requirements
- R1: With in_mode = 0, lane e is out_vec[32e+31:32e], and its sub-element i in each source is the signed byte at bits [8(4e+i)+7 : 8(4e+i)]. Each 128-bit segment holds four lanes.
- R2: With in_mode = 1, lane e is out_vec[64e+63:64e], and its sub-element i is the signed halfword at bits [16(4e+i)+15 : 16(4e+i)]. Each segment holds two lanes.
- R3: Lane e adds, to acc_in lane e, the sum over i = 0..3 of a[4e+i]·b[4s+i], where s = e − (e mod lanes_per_segment) + index. The index selects the same group in every 128-bit segment, and that group is shared by all lanes of the segment.
- R4: In mode 0 the index is in_index[1:0]. In mode 1 only in_index[0] is used, and in_index[1] has no effect on the result.
- R5: Lane results are truncated to the lane width, so overflow wraps modulo 2^32 or 2^64 and never saturates.
- R6: Every lane is updated on every operation. When either source is all zero, the output equals the accumulator input.
- R7: out_valid is high exactly in the cycle after each cycle in which in_valid is high. Operands, mode and index are all sampled in that same input cycle.
- R8: While in_valid is low, out_vec keeps its last value, whatever the other inputs do.
- R9: A synchronous active-high reset clears out_valid and out_vec to zero.
- R10: Elaboration is rejected unless VL is a positive multiple of 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_mode | input | 1 | 0: byte into 32-bit lanes, 1: halfword into 64-bit lanes |
| in_index | input | 2 | Group index within each 128-bit segment |
| src_a | input | VL | First source, per-lane sub-elements |
| src_b | input | VL | Second source, indexed groups |
| acc_in | input | VL | Accumulator operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_vec | output | VL | Accumulated result vector |

## Verification
On every cycle, the assertions check four things: the one-cycle valid timing, that the output holds while idle, that the reset state is clean, and that an all-zero source returns the accumulator unchanged. Only the bench's scenarios can show that the arithmetic is correct. That means the sign handling of the extreme byte and halfword products, wrap-around of the lane sums, broadcast of the indexed group for every index value in both formats, and the ignored upper index bit in the halfword format.

// File: rtl/sdot_pkg.sv
package sdot_pkg;

    localparam int SEG_W  = 128;
    localparam int W_NARROW = 32;
    localparam int W_WIDE   = 64;

    typedef enum logic {
        MODE_B8  = 1'b0,
        MODE_H16 = 1'b1
    } sdot_mode_e;

    typedef struct packed {
        logic       valid;
        sdot_mode_e mode;
        logic [1:0] index;
    } sdot_ctrl_t;

    function automatic logic [31:0] dot4_acc_s8(
        input logic [31:0] a,
        input logic [31:0] b,
        input logic [31:0] acc
    );
        logic signed [17:0] sum;
        logic signed [15:0] prod;
        sum = '0;
        for (int i = 0; i < 4; i++) begin
            prod = $signed(a[i*8 +: 8]) * $signed(b[i*8 +: 8]);
            sum  = sum + 18'(prod);
        end
        return acc + 32'(sum);
    endfunction

    function automatic logic [63:0] dot4_acc_s16(
        input logic [63:0] a,
        input logic [63:0] b,
        input logic [63:0] acc
    );
        logic signed [33:0] sum;
        logic signed [31:0] prod;
        sum = '0;
        for (int i = 0; i < 4; i++) begin
            prod = $signed(a[i*16 +: 16]) * $signed(b[i*16 +: 16]);
            sum  = sum + 34'(prod);
        end
        return acc + 64'(sum);
    endfunction

endpackage

// File: rtl/sdot_group_bcast.sv
module sdot_group_bcast
    import sdot_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic [VL-1:0] src_b,
    input  sdot_mode_e    mode,
    input  logic [1:0]    index,
    output logic [VL-1:0] bc_out
);
    localparam int NSEG = VL / SEG_W;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic [SEG_W-1:0]    seg;
        logic [W_NARROW-1:0] grp_n;
        logic [W_WIDE-1:0]   grp_w;

        assign seg = src_b[g*SEG_W +: SEG_W];

        always_comb begin
            grp_n = seg[index*W_NARROW +: W_NARROW];
            grp_w = seg[index[0]*W_WIDE +: W_WIDE];
        end

        assign bc_out[g*SEG_W +: SEG_W] = (mode == MODE_H16) ? {2{grp_w}} : {4{grp_n}};
    end

endmodule

// File: rtl/sdot_lane_s8.sv
module sdot_lane_s8
    import sdot_pkg::*;
(
    input  logic [W_NARROW-1:0] a,
    input  logic [W_NARROW-1:0] b,
    input  logic [W_NARROW-1:0] acc,
    output logic [W_NARROW-1:0] res
);
    assign res = dot4_acc_s8(a, b, acc);
endmodule

// File: rtl/sdot_lane_s16.sv
module sdot_lane_s16
    import sdot_pkg::*;
(
    input  logic [W_WIDE-1:0] a,
    input  logic [W_WIDE-1:0] b,
    input  logic [W_WIDE-1:0] acc,
    output logic [W_WIDE-1:0] res
);
    assign res = dot4_acc_s16(a, b, acc);
endmodule

// File: rtl/seg_dot_acc.sv
module seg_dot_acc
    import sdot_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_mode,
    input  logic [1:0]    in_index,
    input  logic [VL-1:0] src_a,
    input  logic [VL-1:0] src_b,
    input  logic [VL-1:0] acc_in,
    output logic          out_valid,
    output logic [VL-1:0] out_vec
);
    localparam int N_NARROW = VL / W_NARROW;
    localparam int N_WIDE   = VL / W_WIDE;

    // R10: the vector must be a whole number of segments
    if ((VL % SEG_W) != 0 || VL < SEG_W) begin : g_vl_bad
        $error("seg_dot_acc: VL must be a positive multiple of 128");
    end

    sdot_ctrl_t    ctrl;
    logic [VL-1:0] b_bc;
    logic [VL-1:0] res_n;
    logic [VL-1:0] res_w;
    logic [VL-1:0] res_sel;

    assign ctrl = '{valid: in_valid, mode: sdot_mode_e'(in_mode), index: in_index};

    sdot_group_bcast #(.VL(VL)) i_bcast (
        .src_b  (src_b),
        .mode   (ctrl.mode),
        .index  (ctrl.index),
        .bc_out (b_bc)
    );

    for (genvar l = 0; l < N_NARROW; l++) begin : g_narrow
        sdot_lane_s8 i_lane (
            .a   (src_a [l*W_NARROW +: W_NARROW]),
            .b   (b_bc  [l*W_NARROW +: W_NARROW]),
            .acc (acc_in[l*W_NARROW +: W_NARROW]),
            .res (res_n [l*W_NARROW +: W_NARROW])
        );
    end

    for (genvar l = 0; l < N_WIDE; l++) begin : g_wide
        sdot_lane_s16 i_lane (
            .a   (src_a [l*W_WIDE +: W_WIDE]),
            .b   (b_bc  [l*W_WIDE +: W_WIDE]),
            .acc (acc_in[l*W_WIDE +: W_WIDE]),
            .res (res_w [l*W_WIDE +: W_WIDE])
        );
    end

    assign res_sel = (ctrl.mode == MODE_H16) ? res_w : res_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= ctrl.valid;
            if (ctrl.valid) begin
                out_vec <= res_sel;
            end
        end
    end

endmodule

// File: rtl/sdot_checker.sv
module sdot_checker #(
    parameter int VL = 256
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [VL-1:0] src_a,
    input logic [VL-1:0] src_b,
    input logic [VL-1:0] acc_in,
    input logic          out_valid,
    input logic [VL-1:0] out_vec
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R7

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_vec)); // R8

    AST_ZERO_A_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_a == '0) |=> out_vec == $past(acc_in)); // R6

    AST_ZERO_B_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_b == '0) |=> out_vec == $past(acc_in)); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && out_vec == '0)); // R9

endmodule

bind seg_dot_acc sdot_checker #(.VL(VL)) i_sdot_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .src_a     (src_a),
    .src_b     (src_b),
    .acc_in    (acc_in),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/test_seg_dot_acc.sv
module test_seg_dot_acc;
    localparam int VL = 256;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_mode;
    logic [1:0]    in_index;
    logic [VL-1:0] src_a, src_b, acc_in;
    logic          out_valid;
    logic [VL-1:0] out_vec;

    typedef struct {
        logic [VL-1:0] vec;
        string         tag;
    } exp_t;

    exp_t          exp_q[$];
    logic [VL-1:0] last_exp;
    bit            have_last = 1'b0;
    bit            hold_phase = 1'b0;
    bit            done = 1'b0;
    int            total = 0;
    int            bad = 0;

    always #4 clk = ~clk;

    seg_dot_acc #(.VL(VL)) i_seg_dot_acc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_index(in_index), .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic logic [VL-1:0] model(input bit mode, input logic [1:0] idx,
                                            input logic [VL-1:0] a, b, acc);
        logic [VL-1:0] r;
        longint sum;
        int s;
        int ix;
        r = '0;
        if (!mode) begin
            ix = int'(idx);
            for (int e = 0; e < VL/32; e++) begin
                s = e - (e % 4) + ix;
                sum = longint'($signed(acc[e*32 +: 32]));
                for (int i = 0; i < 4; i++)
                    sum += longint'($signed(a[(4*e+i)*8 +: 8])) * longint'($signed(b[(4*s+i)*8 +: 8]));
                r[e*32 +: 32] = sum[31:0];
            end
        end else begin
            ix = int'(idx[0]);
            for (int e = 0; e < VL/64; e++) begin
                s = e - (e % 2) + ix;
                sum = longint'(acc[e*64 +: 64]);
                for (int i = 0; i < 4; i++)
                    sum += longint'($signed(a[(4*e+i)*16 +: 16])) * longint'($signed(b[(4*s+i)*16 +: 16]));
                r[e*64 +: 64] = sum;
            end
        end
        return r;
    endfunction

    function automatic logic [VL-1:0] rand_vec();
        logic [VL-1:0] v;
        for (int k = 0; k < VL/32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [VL-1:0] fill(input logic [63:0] w);
        logic [VL-1:0] v;
        for (int k = 0; k < VL/64; k++) v[k*64 +: 64] = w;
        return v;
    endfunction

    task automatic drive(input bit mode, input logic [1:0] idx,
                         input logic [VL-1:0] a, b, acc, input string tag);
        exp_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_mode  = mode;
        in_index = idx;
        src_a    = a;
        src_b    = b;
        acc_in   = acc;
        it.vec   = model(mode, idx, a, b, acc);
        it.tag   = tag;
        exp_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_mode  = 1'($urandom);
            in_index = 2'($urandom);
            src_a    = rand_vec();
            src_b    = rand_vec();
            acc_in   = rand_vec();
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R7: out_valid with no pending operation, actual=1 expected=0");
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    if (out_vec !== it.vec) begin
                        bad++;
                        $display("FAIL %s: actual=%h expected=%h", it.tag, out_vec, it.vec);
                    end
                    last_exp  = it.vec;
                    have_last = 1'b1;
                end
            end else if (hold_phase && have_last) begin
                total++; // R8
                if (out_vec !== last_exp) begin
                    bad++;
                    $display("FAIL R8: idle output changed, actual=%h expected=%h", out_vec, last_exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0; in_mode = 1'b0; in_index = 2'd0;
        src_a = '0; src_b = '0; acc_in = '0;
        repeat (3) @(negedge clk);
        total++; // R9
        if (out_valid !== 1'b0 || out_vec !== '0) begin
            bad++;
            $display("FAIL R9: reset state actual=%b/%h expected=0/0", out_valid, out_vec);
        end
        rst = 1'b0;
        idle(2);

        // R1 / R3: extreme byte products, every index
        for (int ix = 0; ix < 4; ix++)
            drive(1'b0, 2'(ix), fill(64'h8080808080808080), fill(64'h8080808080808080), '0, "R1");
        // R2: extreme halfword products, both indices
        for (int ix = 0; ix < 2; ix++)
            drive(1'b1, 2'(ix), fill(64'h8000800080008000), fill(64'h8000800080008000), '0, "R2");
        idle(1);
        // R5: accumulator wrap in both formats
        drive(1'b0, 2'd1, fill(64'h7F7F7F7F7F7F7F7F), fill(64'h7F7F7F7F7F7F7F7F),
              fill(64'h7FFFFFFF7FFFFFFF), "R5");
        drive(1'b1, 2'd0, fill(64'h8000800080008000), fill(64'h8000800080008000),
              fill(64'h7FFFFFFFFFFFFFFF), "R5");
        drive(1'b0, 2'd3, fill(64'h8080808080808080), fill(64'h7F7F7F7F7F7F7F7F),
              fill(64'h8000000080000000), "R5");
        idle(1);
        // R3: distinct groups per segment, every index, both formats
        for (int ix = 0; ix < 4; ix++)
            drive(1'b0, 2'(ix), rand_vec(), rand_vec(), rand_vec(), "R3");
        for (int ix = 0; ix < 2; ix++)
            drive(1'b1, 2'(ix), rand_vec(), rand_vec(), rand_vec(), "R3");
        // R4: upper index bit ignored in halfword format
        begin
            logic [VL-1:0] a, b, c;
            a = rand_vec(); b = rand_vec(); c = rand_vec();
            drive(1'b1, 2'd2, a, b, c, "R4");
            drive(1'b1, 2'd3, a, b, c, "R4");
        end
        // R6: zero sources return accumulator
        drive(1'b0, 2'd2, '0, rand_vec(), rand_vec(), "R6");
        drive(1'b1, 2'd1, rand_vec(), '0, rand_vec(), "R6");
        idle(1);
        // mixed random traffic with gaps
        for (int k = 0; k < 40; k++) begin
            drive(1'($urandom), 2'($urandom), rand_vec(), rand_vec(), rand_vec(), "R3");
            if ($urandom % 3 == 0) idle(1 + ($urandom % 3));
        end
        idle(2);
        // R8: idle hold with changing inputs
        hold_phase = 1'b1;
        idle(6);
        hold_phase = 1'b0;

        total++; // R7
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R7: results missing, actual=%0d pending expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule